// File: doc/BRIEF.md
# Rising-Edge Dead-Time Generator

This block takes one pulse-width-modulated input and produces a copy of it whose rising edges are held back by a programmable number of clock cycles. Falling edges pass straight through. The delayed copy drives one side of a pair of power switches, so that this side turns on only after the other side has had time to turn off. When the input high time is no longer than the programmed delay, the output gives no pulse for that period.

Software writes the delay into a pending register. The value takes effect only when the counter-zero strobe of the PWM counter arrives. The external counter supplies that strobe. In immediate mode, the first counter-zero strobe after the write loads the value into the active register. In synchronous mode, the load also needs a synchronous-update request. The block latches that request until a counter-zero strobe consumes it. An enable input turns the delay off, and the output then follows the input through one register stage.

Top module: `db_rise_delay`

## Requirements
- R1: After reset, the output is low, the read-back value is zero and the active delay is zero. With delay zero, a high pulse of H cycles comes out with a latency of one cycle and a high time of H cycles.
- R2: The read-back port returns the low 12 bits of the most recent write. Bits 15 to 12 always read as zero. The read-back shows the pending value, not the active one.
- R3: While `db_enable` is low, the output equals the input as sampled at the previous clock edge, whatever delay is active.
- R4: While enabled with active delay D, an input that rises and stays high for H > D cycles produces an output that rises D+1 cycles after the input and stays high for H−D cycles.
- R5: With the block enabled, a low input drives the output low at the next clock edge. It also cancels any countdown in progress, so the next rising edge is delayed by the full D cycles.
- R6: When an input high pulse lasts H ≤ D cycles, the output stays low for the whole pulse.
- R7: With `sync_mode` = 0, a pending delay becomes active at the first `cnt_zero` strobe after the write. Before that strobe, the earlier active delay remains in use.
- R8: With `sync_mode` = 1, a pending delay becomes active only at a `cnt_zero` strobe that arrives while a `sync_req` is latched, or in the same cycle as a `sync_req`. Every `cnt_zero` strobe clears the latched request.
- R9: A second write before the load replaces the pending value. The first value never becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | PWM input signal |
| db_enable | input | 1 | 1 = apply the rising-edge delay, 0 = bypass |
| sync_mode | input | 1 | 0 = load at the next counter-zero strobe, 1 = load only after a synchronous request |
| sync_req | input | 1 | One-cycle synchronous-update request pulse |
| cnt_zero | input | 1 | One-cycle pulse: the PWM counter has reached zero |
| wr_en | input | 1 | Write strobe for the delay register |
| wr_data | input | 16 | Write data; bits 11:0 hold the delay |
| rd_data | output | 16 | Pending delay, zero-extended |
| pwm_out | output | 1 | PWM output with delayed rising edges |

## Verification
The assertions assume that `cnt_zero` and `sync_req` are single-cycle strobes. They also assume that all inputs are stable around each rising clock edge, and that reset lasts for at least one edge, which gives every `$past` reference a defined value. The bench changes every input only on the falling clock edge and drives each strobe high for exactly one cycle. It never pulses `cnt_zero` while a measured pulse is in progress, so each pulse is measured against a single active delay.

// File: rtl/db_rise_delay.sv
module db_rise_delay #(
  parameter int DLY_W = 12,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             db_enable,
  input  logic             sync_mode,
  input  logic             sync_req,
  input  logic             cnt_zero,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             pwm_out
);
  localparam int PAD_W = REG_W - DLY_W;

  logic [DLY_W-1:0] pend, active, cnt;
  logic             pend_vld, sync_flag, out_q;
  logic             load;
  logic             unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:DLY_W];
  assign load      = cnt_zero & pend_vld & (~sync_mode | sync_flag | sync_req);
  assign rd_data   = {{PAD_W{1'b0}}, pend};
  assign pwm_out   = out_q;

  // double-buffered delay value and update request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      pend_vld  <= 1'b0;
      active    <= '0;
      sync_flag <= 1'b0;
    end else begin
      if (wr_en) pend <= wr_data[DLY_W-1:0];
      pend_vld <= wr_en | (pend_vld & ~load);
      if (load) active <= pend;
      if (cnt_zero)      sync_flag <= 1'b0;
      else if (sync_req) sync_flag <= 1'b1;
    end
  end

  // rising-edge delay
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (!db_enable) begin
      cnt   <= '0;
      out_q <= pwm_in;
    end else if (!pwm_in) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (!out_q) begin
      if (cnt >= active) out_q <= 1'b1;
      else               cnt   <= cnt + 1'b1;
    end
  end

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:DLY_W] == '0);
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[DLY_W-1:0] == $past(wr_data[DLY_W-1:0]));
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !db_enable |=> pwm_out == $past(pwm_in));
  a_r5_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    (db_enable && !pwm_in) |=> !pwm_out);
  a_r6_no_high_without_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(pwm_in));
  a_r7_hold_between_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_zero |=> $stable(active));
  a_r7_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !sync_mode && pend_vld) |=> active == $past(rd_data[DLY_W-1:0]));
  a_r8_wait_for_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && sync_mode && !sync_flag && !sync_req) |=> $stable(active));
  a_r8_request_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |=> !sync_flag);
endmodule

// File: tb/sim_db_rise_delay.sv
module sim_db_rise_delay;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, db_enable = 1'b0, sync_mode = 1'b0;
  logic sync_req = 1'b0, cnt_zero = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic pwm_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  db_rise_delay u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .db_enable(db_enable),
    .sync_mode(sync_mode), .sync_req(sync_req), .cnt_zero(cnt_zero),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_dly(logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic zero_strobe();
    @(negedge clk); cnt_zero = 1'b1;
    @(negedge clk); cnt_zero = 1'b0;
  endtask

  task automatic req_strobe();
    @(negedge clk); sync_req = 1'b1;
    @(negedge clk); sync_req = 1'b0;
  endtask

  // drive a high pulse of h cycles; report first high sample index and high count
  task automatic pulse(int h, output int lat, output int width);
    lat = 0; width = 0;
    @(negedge clk); pwm_in = 1'b1;
    for (int k = 1; k <= h + 4; k++) begin
      @(negedge clk);
      if (pwm_out) begin
        width++;
        if (lat == 0) lat = k;
      end
      if (k == h) pwm_in = 1'b0;
    end
  endtask

  task automatic t_reset();
    int lat, w;
    check("R1 out", int'(pwm_out), 0);
    check("R1 rd", int'(rd_data), 0);
    @(negedge clk); db_enable = 1'b1;
    pulse(3, lat, w);
    check("R1 zero-delay latency", lat, 1);
    check("R1 zero-delay width", w, 3);
  endtask

  task automatic t_readback();
    write_dly(16'hF005);
    check("R2 readback masked", int'(rd_data), 5);
  endtask

  task automatic t_immediate();
    int lat, w;
    write_dly(16'd4);
    pulse(8, lat, w);
    check("R7 old delay before zero", lat, 1);
    zero_strobe();
    check("R2 rd shows pending", int'(rd_data), 4);
    pulse(8, lat, w);
    check("R7 R4 latency", lat, 5);
    check("R4 width", w, 4);
  endtask

  task automatic t_swallow();
    int lat, w;
    pulse(4, lat, w);
    check("R6 equal swallowed", w, 0);
    pulse(3, lat, w);
    check("R6 shorter swallowed", w, 0);
    pulse(5, lat, w);
    check("R4 one-cycle width", w, 1);
  endtask

  task automatic t_fall();
    int lat, w;
    @(negedge clk); pwm_in = 1'b1;
    repeat (3) @(negedge clk);
    pwm_in = 1'b0;
    @(negedge clk);
    pulse(8, lat, w);
    check("R5 countdown restarted", lat, 5);
    check("R5 width after cancel", w, 4);
    @(negedge clk); pwm_in = 1'b1;
    repeat (6) @(negedge clk);
    pwm_in = 1'b0;
    @(negedge clk);
    check("R5 low after fall", int'(pwm_out), 0);
  endtask

  task automatic t_disable();
    int lat, w;
    @(negedge clk); db_enable = 1'b0;
    pulse(3, lat, w);
    check("R3 bypass latency", lat, 1);
    check("R3 bypass width", w, 3);
    @(negedge clk); db_enable = 1'b1;
  endtask

  task automatic t_sync();
    int lat, w;
    @(negedge clk); sync_mode = 1'b1;
    write_dly(16'd2);
    zero_strobe();
    pulse(8, lat, w);
    check("R8 no load without request", lat, 5);
    req_strobe();
    repeat (2) @(negedge clk);
    zero_strobe();
    pulse(8, lat, w);
    check("R8 load after latched request", lat, 3);
    check("R8 width", w, 6);
    write_dly(16'd6);
    req_strobe();
    zero_strobe();
    write_dly(16'd0);
    zero_strobe();
    pulse(8, lat, w);
    check("R8 request cleared by zero", lat, 7);
  endtask

  task automatic t_rewrite();
    int lat, w;
    @(negedge clk); sync_mode = 1'b0;
    write_dly(16'd7);
    write_dly(16'd1);
    zero_strobe();
    pulse(8, lat, w);
    check("R9 earlier value discarded", lat, 2);
    check("R9 width", w, 7);
    check("R9 rd", int'(rd_data), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_immediate();
    t_swallow();
    t_fall();
    t_disable();
    t_sync();
    t_rewrite();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule